// File: doc/BRIEF.md
# Serial-Clocked Wiper Step Controller

This block runs the fine-tune phase of a digital potentiometer's two-wire slave interface. The instruction decoder opens the phase once it has acknowledged a step-mode command. The decoder passes in a one-cycle arm strobe and the number of the target channel. From then on, every complete clock-high pulse from the bus master produces one step strobe toward the wiper register bank. A data line that is high during the pulse moves the wiper up, toward the high terminal. A low data line moves it down, toward the low terminal.

The bus lines arrive already synchronised and oversampled by the system clock. START and STOP arrive as one-cycle strobes from a separate condition detector. A STOP closes the phase. A START also closes it and raises a hand-back pulse, so that the decoder returns to waiting for the identification byte. The block never drives the data line, and it does not decode commands or hold register contents.

Top module: `wiper_step_ctrl`

## Requirements
- R1: After reset, `phase_on`, `hand_back` and every bit of `step_up` and `step_dn` are 0.
- R2: While the phase is open, a clock pulse with the data line high at its rising edge produces a one-cycle pulse on `step_up[c]`. The pulse appears in the cycle after the falling edge of the clock is seen. Here c is the channel latched at arm.
- R3: While the phase is open, a clock pulse with the data line low at its rising edge produces a one-cycle pulse on `step_dn[c]`, with the same timing as R2.
- R4: `ch_sel` is a binary channel number, captured in the cycle `arm` is high. Bit i of `step_up` and `step_dn` belongs to channel i. At most one bit of the two buses together is high in any cycle.
- R5: Clock pulses while the phase is closed produce no strobe.
- R6: The direction is taken only at the rising clock edge. A change of the data line while the clock is high does not change the direction of that step.
- R7: `stop_det` closes the phase (`phase_on` is 0 in the next cycle). A clock pulse cut by the STOP produces no strobe, and later pulses produce none.
- R8: `start_det` closes the phase. If the phase was open, `hand_back` pulses for one cycle in the next cycle.
- R9: A clock pulse that is already high when `arm` arrives produces no strobe. Counting starts with the next rising edge.
- R10: Each complete clock pulse in an open phase yields exactly one strobe cycle, so N pulses give N strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_s | input | 1 | Synchronised bus clock level |
| sda_s | input | 1 | Synchronised bus data level |
| arm | input | 1 | One-cycle strobe from the decoder that opens the phase |
| ch_sel | input | SEL_W | Binary number of the target channel |
| start_det | input | 1 | One-cycle START condition strobe |
| stop_det | input | 1 | One-cycle STOP condition strobe |
| step_up | output | NUM_CH | One-cycle per-channel step toward the high terminal |
| step_dn | output | NUM_CH | One-cycle per-channel step toward the low terminal |
| phase_on | output | 1 | Step phase currently open |
| hand_back | output | 1 | One-cycle pulse: a START ended an open phase |

## Verification
The bench targets corrupted internal state. A stuck or stale pending flag shows up as a strobe after a STOP-cut pulse, or as a strobe for a pulse that began before arm. A wrong latched channel or direction moves the wrong bit of the strobe buses. Each of these faults shows at the ports one cycle after the falling edge of the clock pulse concerned. A phase flag that fails to clear shows as a strobe on the first pulse after STOP or START, and the scoreboard reports it as an unexpected item.

// File: rtl/wiper_step_ctrl.sv
module wiper_step_ctrl #(
  parameter int NUM_CH = 4,
  localparam int SEL_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              arm,
  input  logic [SEL_W-1:0]  ch_sel,
  input  logic              start_det,
  input  logic              stop_det,
  output logic [NUM_CH-1:0] step_up,
  output logic [NUM_CH-1:0] step_dn,
  output logic              phase_on,
  output logic              hand_back
);

  logic             scl_q;
  logic             pend;
  logic             pend_up;
  logic [SEL_W-1:0] ch_q;

  wire rise = scl_s & ~scl_q;
  wire fall = ~scl_s & scl_q;
  wire [NUM_CH-1:0] ch_bit = NUM_CH'(1) << ch_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q     <= 1'b1;
      phase_on  <= 1'b0;
      pend      <= 1'b0;
      pend_up   <= 1'b0;
      ch_q      <= '0;
      step_up   <= '0;
      step_dn   <= '0;
      hand_back <= 1'b0;
    end else begin
      scl_q     <= scl_s;
      step_up   <= '0;
      step_dn   <= '0;
      hand_back <= 1'b0;
      if (start_det || stop_det) begin
        phase_on  <= 1'b0;
        pend      <= 1'b0;
        hand_back <= start_det & phase_on;
      end else if (arm) begin
        phase_on <= 1'b1;
        ch_q     <= ch_sel;
        pend     <= 1'b0;
      end else if (phase_on) begin
        if (rise) begin
          pend    <= 1'b1;
          pend_up <= sda_s;
        end else if (fall && pend) begin
          pend <= 1'b0;
          if (pend_up) step_up <= ch_bit;
          else         step_dn <= ch_bit;
        end
      end
    end
  end

endmodule

// File: rtl/wiper_step_ctrl_chk.sv
module wiper_step_ctrl_chk #(
  parameter int NUM_CH = 4,
  localparam int SEL_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_det,
  input logic              stop_det,
  input logic [NUM_CH-1:0] step_up,
  input logic [NUM_CH-1:0] step_dn,
  input logic              phase_on,
  input logic              hand_back
);
  wire any_step = |step_up || |step_dn;

  a_r4_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({step_up, step_dn}));
  a_r10_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    any_step |=> !any_step);
  a_r5_needs_phase: assert property (@(posedge clk) disable iff (!rst_n)
    any_step |-> $past(phase_on));
  a_r7_stop_closes: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !phase_on);
  a_r8_hand_back: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det && phase_on) |=> hand_back);
  a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    hand_back |-> $past(start_det));
endmodule

bind wiper_step_ctrl wiper_step_ctrl_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_det(start_det), .stop_det(stop_det),
  .step_up(step_up), .step_dn(step_dn), .phase_on(phase_on),
  .hand_back(hand_back)
);

// File: tb/wiper_step_ctrl_tb.sv
module wiper_step_ctrl_tb;
  localparam int NUM_CH = 4;
  localparam int SEL_W  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_s = 1'b1, sda_s = 1'b1, arm = 1'b0, start_det = 1'b0, stop_det = 1'b0;
  logic [SEL_W-1:0] ch_sel = '0;
  logic [NUM_CH-1:0] step_up, step_dn;
  logic phase_on, hand_back;

  int checks = 0, errors = 0, strobes = 0, hb_seen = 0;
  int expq[$];
  bit exp_on = 0;
  int exp_ch = 0;
  bit done = 0;

  always #5 clk = ~clk;

  wiper_step_ctrl #(.NUM_CH(NUM_CH)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s), .arm(arm),
    .ch_sel(ch_sel), .start_det(start_det), .stop_det(stop_det),
    .step_up(step_up), .step_dn(step_dn), .phase_on(phase_on),
    .hand_back(hand_back)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // scoreboard monitor: item = dir*16 + channel
  always @(posedge clk) begin
    #2;
    if (rst_n && (|step_up || |step_dn)) begin
      int act;
      act = -1;
      strobes++;
      for (int i = 0; i < NUM_CH; i++) begin
        if (step_up[i]) act = 16 + i;
        if (step_dn[i]) act = i;
      end
      if (expq.size() == 0) check(0, "R5/R7/R9 unexpected strobe", act, -1);
      else begin
        int e;
        e = expq.pop_front();
        check(act == e, "R2/R3/R4 strobe", act, e);
      end
    end
    if (rst_n && hand_back) hb_seen++;
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic arm_ch(input int c);
    @(negedge clk); arm = 1'b1; ch_sel = SEL_W'(c);
    @(negedge clk); arm = 1'b0;
    exp_on = 1; exp_ch = c;
  endtask

  task automatic pulse(input bit dir, input bit flip);
    @(negedge clk); scl_s = 1'b0;
    wait_n(2); sda_s = dir;
    wait_n(2); scl_s = 1'b1;
    wait_n(2); if (flip) sda_s = ~dir;
    wait_n(2); scl_s = 1'b0;
    if (exp_on) expq.push_back(dir * 16 + exp_ch);
    wait_n(4);
  endtask

  task automatic stop_seq();
    @(negedge clk); scl_s = 1'b0;
    wait_n(2); sda_s = 1'b0;
    wait_n(2); scl_s = 1'b1;
    wait_n(2); sda_s = 1'b1; stop_det = 1'b1;
    @(negedge clk); stop_det = 1'b0;
    exp_on = 0;
    wait_n(3);
  endtask

  task automatic start_seq();
    @(negedge clk); scl_s = 1'b0;
    wait_n(2); sda_s = 1'b1;
    wait_n(2); scl_s = 1'b1;
    wait_n(2); sda_s = 1'b0; start_det = 1'b1;
    @(negedge clk); start_det = 1'b0;
    exp_on = 0;
    wait_n(3);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int s0;
    wait_n(4);
    check(phase_on == 0, "R1 phase_on", phase_on, 0);
    check(step_up == 0 && step_dn == 0, "R1 strobes", {step_up, step_dn}, 0);
    check(hand_back == 0, "R1 hand_back", hand_back, 0);
    rst_n = 1'b1;
    wait_n(2);

    // R5: pulses before arm are ignored
    s0 = strobes;
    pulse(1, 0); pulse(0, 0);
    check(strobes == s0, "R5 no strobe while closed", strobes - s0, 0);

    // R2, R3, R4, R10: mixed steps on channel 2
    arm_ch(2);
    check(phase_on == 1, "R4 phase opens on arm", phase_on, 1);
    s0 = strobes;
    pulse(1, 0); pulse(1, 0); pulse(0, 0); pulse(1, 0); pulse(0, 0);
    check(strobes - s0 == 5, "R10 one strobe per pulse", strobes - s0, 5);

    // R6: data flips during high
    s0 = strobes;
    pulse(1, 1); pulse(0, 1);
    check(strobes - s0 == 2, "R6 flip keeps one strobe each", strobes - s0, 2);

    // R7: stop ends phase, cut pulse gives nothing
    s0 = strobes;
    stop_seq();
    check(phase_on == 0, "R7 phase closed", phase_on, 0);
    check(strobes == s0, "R7 no strobe from stop pulse", strobes - s0, 0);
    pulse(1, 0);
    check(strobes == s0, "R7 ignored after stop", strobes - s0, 0);

    // R4: channel 3, then channel 0
    arm_ch(3);
    pulse(0, 0); pulse(1, 0);
    stop_seq();
    arm_ch(0);
    pulse(1, 0);

    // R8: start ends phase with hand_back
    s0 = hb_seen;
    start_seq();
    check(hb_seen - s0 == 1, "R8 hand_back pulse", hb_seen - s0, 1);
    check(phase_on == 0, "R8 phase closed by start", phase_on, 0);
    s0 = strobes;
    pulse(0, 0);
    check(strobes == s0, "R8 ignored after start", strobes - s0, 0);

    // R8: start with phase closed gives no hand_back
    s0 = hb_seen;
    start_seq();
    check(hb_seen == s0, "R8 no hand_back when closed", hb_seen - s0, 0);

    // R9: arm while clock is high
    @(negedge clk); scl_s = 1'b1; sda_s = 1'b1;
    wait_n(2);
    arm_ch(1);
    s0 = strobes;
    wait_n(2); scl_s = 1'b0;
    wait_n(4);
    check(strobes == s0, "R9 pulse before arm not counted", strobes - s0, 0);
    pulse(0, 0);
    check(strobes - s0 == 1, "R9 next pulse counted", strobes - s0, 1);
    stop_seq();

    wait_n(4);
    check(expq.size() == 0, "R10 all expected strobes seen", expq.size(), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule